// File: doc/BRIEF.md
# Round-Robin Stream Fan-Out Switch

This block takes one upstream data stream and spreads it over a set of channel outputs. Each output feeds its own downstream replay path. The data and end-of-packet marker are wired unchanged to every output, so the wide data path holds no multiplexer. Only the handshake is steered. Each output's valid is the upstream valid gated by that channel's select bit. The upstream ready comes from one selected channel only.

The select vector has two possible sources. In direct mode it is a control input that software drives, and the outputs follow it at once. In round-robin mode an internal arbiter owns the select. It grants one enabled channel at a time and moves to the next enabled channel only when a beat that ends a packet is accepted. A change to the mode, or to the set of enabled channels, is applied only between packets. Because of this, a packet is never split across two channels.

Top module: `stream_fanout_switch`

## Requirements
- R1: `s_tdata` and `s_tlast` appear unchanged on every channel's `m_tdata` slice and `m_tlast` bit in the same cycle, whatever the select state.
- R2: `m_tvalid[i]` is high exactly when `s_tvalid` is high and channel i is selected.
- R3: `s_tready` equals `m_tready` of the lowest-numbered selected channel, and the ready inputs of all other channels have no effect. With no channel selected, `s_tready` is low.
- R4: While the applied mode is direct (`mode_arb` = 0), the select vector equals `direct_sel` in the same cycle, and any number of its bits may be set.
- R5: While the applied mode is round-robin (`mode_arb` = 1), at most one channel is selected. When `chan_enable` is all zero, no channel is selected and `s_tready` stays low.
- R6: During reset the applied mode is direct and the arbiter holds no grant. At the first idle clock edge after reset, the grant goes to the lowest-numbered enabled channel.
- R7: When a beat with `s_tlast` = 1 is accepted in round-robin mode, the grant moves to the next higher-numbered enabled channel and wraps from the top channel to channel 0. If the current channel is the only one enabled, the grant stays where it is.
- R8: The grant does not move on an accepted beat that has `s_tlast` = 0, or on a `s_tlast` beat that is not accepted.
- R9: The mode and the enable set are applied only at an edge after which no packet is open. That is either an edge with no packet in progress or the edge that accepts the final beat of a packet. While a packet is open, changes to `mode_arb` and `chan_enable` have no effect on the select.
- R10: At an edge with no packet open, if the held grant is not in `chan_enable`, the grant moves to the lowest-numbered enabled channel. If no channel is enabled, the grant is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_arb | input | 1 | Requested mode: 0 direct, 1 round-robin |
| direct_sel | input | NCH | Channel select used in direct mode |
| chan_enable | input | NCH | Channels that take part in round-robin arbitration |
| s_tdata | input | DW | Upstream data |
| s_tvalid | input | 1 | Upstream valid |
| s_tlast | input | 1 | Upstream end-of-packet marker |
| s_tready | output | 1 | Upstream ready, taken from the selected channel |
| m_tdata | output | NCH*DW | Per-channel data; slice i is channel i |
| m_tvalid | output | NCH | Per-channel valid |
| m_tlast | output | NCH | Per-channel end-of-packet marker |
| m_tready | input | NCH | Per-channel ready |

## Verification
Direct mode is swept over every select pattern, each time with a random ready vector. This separates correct valid gating and lowest-channel ready picking from a design that ORs the readies or ignores the select. Round-robin mode is swept over every enable pattern with packets of one, two and three beats. The grant order shows whether the arbiter moves on every beat instead of only at the packet end, and whether it skips disabled channels and wraps correctly. A directed sequence changes the mode and the enable set in the middle of a packet and while idle, to show that changes are held back until the boundary. A random phase with stalled readies and un-accepted end beats checks that only accepted packet ends move the grant.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    localparam int unsigned FO_CHANNELS = 8;
    localparam int unsigned FO_DATA_W   = 256;

    // Applied source of the channel select vector
    typedef enum logic {
        SEL_DIRECT = 1'b0,
        SEL_ROUND  = 1'b1
    } sel_mode_e;

    // Upstream beat control bundled for internal routing
    typedef struct packed {
        logic valid;
        logic last;
    } beat_ctl_t;

    // Channel index reached by stepping 'step' places past 'base'
    function automatic int wrap_idx(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/fanout_pkt_tracker.sv
module fanout_pkt_tracker
    import fanout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      last,
    input  logic      mode_req,
    output logic      in_pkt,
    output logic      at_boundary,
    output sel_mode_e mode_q
);

    logic in_pkt_next;

    always_comb begin
        in_pkt_next = accept ? ~last : in_pkt;
        at_boundary = ~in_pkt_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt <= 1'b0;
            mode_q <= SEL_DIRECT;
        end else begin
            in_pkt <= in_pkt_next;
            if (at_boundary) begin
                mode_q <= sel_mode_e'(mode_req);
            end
        end
    end

endmodule

// File: rtl/fanout_rr_arbiter.sv
module fanout_rr_arbiter
    import fanout_pkg::*;
#(
    parameter int unsigned NCH = FO_CHANNELS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] enable,
    input  logic           advance,
    input  logic           settle,
    output logic [NCH-1:0] grant
);

    localparam int unsigned   IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [NCH-1:0] ONE  = {{(NCH-1){1'b0}}, 1'b1};

    logic [NCH-1:0]   grant_q;
    logic [NCH-1:0]   grant_d;
    logic [NCH-1:0]   rr_pick;
    logic [NCH-1:0]   low_pick;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] probe;
    logic             found;

    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant_q[i]) cur_idx = IDX_W'(i);
        end
        rr_pick = '0;
        found   = 1'b0;
        probe   = '0;
        for (int k = 1; k <= NCH; k++) begin
            probe = IDX_W'(wrap_idx(int'(cur_idx), k, NCH));
            if (!found && enable[probe]) begin
                rr_pick[probe] = 1'b1;
                found          = 1'b1;
            end
        end
        low_pick = enable & (~enable + ONE);
    end

    always_comb begin
        if (advance) begin
            grant_d = rr_pick;
        end else if (settle && ((grant_q & enable) == '0)) begin
            grant_d = low_pick;
        end else begin
            grant_d = grant_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant_d;
    end

    assign grant = grant_q;

endmodule

// File: rtl/fanout_steer.sv
module fanout_steer
    import fanout_pkg::*;
#(
    parameter int unsigned NCH = FO_CHANNELS,
    parameter int unsigned DW  = FO_DATA_W
) (
    input  logic [NCH-1:0]    sel,
    input  logic [DW-1:0]     s_tdata,
    input  beat_ctl_t         s_ctl,
    output logic              s_tready,
    output logic [NCH*DW-1:0] m_tdata,
    output logic [NCH-1:0]    m_tvalid,
    output logic [NCH-1:0]    m_tlast,
    input  logic [NCH-1:0]    m_tready
);

    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    logic [NCH-1:0] ready_src;

    // Data and marker are plain wires to every channel
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign m_tdata[g*DW +: DW] = s_tdata;
        assign m_tlast[g]          = s_ctl.last;
        assign m_tvalid[g]         = s_ctl.valid & sel[g];
    end

    // Ready comes from the lowest selected channel only
    assign ready_src = sel & (~sel + ONE);
    assign s_tready  = |(ready_src & m_tready);

endmodule

// File: rtl/stream_fanout_switch.sv
module stream_fanout_switch
    import fanout_pkg::*;
#(
    parameter int unsigned NCH = FO_CHANNELS,
    parameter int unsigned DW  = FO_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_arb,
    input  logic [NCH-1:0]    direct_sel,
    input  logic [NCH-1:0]    chan_enable,
    input  logic [DW-1:0]     s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [NCH*DW-1:0] m_tdata,
    output logic [NCH-1:0]    m_tvalid,
    output logic [NCH-1:0]    m_tlast,
    input  logic [NCH-1:0]    m_tready
);

    beat_ctl_t      up_ctl;
    sel_mode_e      mode_q;
    logic           in_pkt;
    logic           at_boundary;
    logic           accept;
    logic           advance;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] sel_w;

    assign up_ctl.valid = s_tvalid;
    assign up_ctl.last  = s_tlast;
    assign accept       = up_ctl.valid & s_tready;
    assign advance      = accept & up_ctl.last & (mode_q == SEL_ROUND);
    assign sel_w        = (mode_q == SEL_ROUND) ? grant : direct_sel;

    fanout_pkt_tracker u_trk (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .last        (up_ctl.last),
        .mode_req    (mode_arb),
        .in_pkt      (in_pkt),
        .at_boundary (at_boundary),
        .mode_q      (mode_q)
    );

    fanout_rr_arbiter #(.NCH(NCH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .enable  (chan_enable),
        .advance (advance),
        .settle  (at_boundary),
        .grant   (grant)
    );

    fanout_steer #(.NCH(NCH), .DW(DW)) u_steer (
        .sel      (sel_w),
        .s_tdata  (s_tdata),
        .s_ctl    (up_ctl),
        .s_tready (s_tready),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tlast  (m_tlast),
        .m_tready (m_tready)
    );

endmodule

// File: rtl/fanout_checker.sv
module fanout_checker #(
    parameter int unsigned NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           mode_arb,
    input logic [NCH-1:0] chan_enable,
    input logic           s_tvalid,
    input logic           s_tlast,
    input logic           s_tready,
    input logic [NCH-1:0] m_tvalid,
    input logic [NCH-1:0] sel,
    input logic           mode_q,
    input logic           in_pkt
);

    // R2: with no upstream valid, no channel sees a valid
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !s_tvalid |-> (m_tvalid == '0));

    // R3: nothing selected means upstream is never ready
    a_r3_no_sel_no_ready: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> !s_tready);

    // R5: arbitrated mode selects at most one channel
    a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> $onehot0(sel));

    // R7: an accepted packet end with two or more enabled channels moves the grant
    a_r7_rotates: assert property (@(posedge clk) disable iff (rst)
        (mode_q && mode_arb && s_tvalid && s_tready && s_tlast
         && ($countones(chan_enable) > 1)) |=> (sel != $past(sel)));

    // R8: an accepted mid-packet beat keeps the grant
    a_r8_hold_mid: assert property (@(posedge clk) disable iff (rst)
        (mode_q && s_tvalid && s_tready && !s_tlast) |=> $stable(sel));

    // R9: the applied mode is frozen while a packet stays open
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (in_pkt && !(s_tvalid && s_tready && s_tlast)) |=> $stable(mode_q));

endmodule

bind stream_fanout_switch fanout_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_arb    (mode_arb),
    .chan_enable (chan_enable),
    .s_tvalid    (s_tvalid),
    .s_tlast     (s_tlast),
    .s_tready    (s_tready),
    .m_tvalid    (m_tvalid),
    .sel         (sel_w),
    .mode_q      (mode_q),
    .in_pkt      (in_pkt)
);

// File: tb/sim_stream_fanout_switch.sv
module sim_stream_fanout_switch;

    localparam int NCH = 8;
    localparam int DW  = 256;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_arb = 1'b0;
    logic [NCH-1:0]    direct_sel = '0;
    logic [NCH-1:0]    chan_enable = '0;
    logic [DW-1:0]     s_tdata = '0;
    logic              s_tvalid = 1'b0;
    logic              s_tlast = 1'b0;
    logic              s_tready;
    logic [NCH*DW-1:0] m_tdata;
    logic [NCH-1:0]    m_tvalid;
    logic [NCH-1:0]    m_tlast;
    logic [NCH-1:0]    m_tready = '0;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // Reference state built from the requirements
    logic           r_inpkt;
    logic           r_mode;
    logic [NCH-1:0] r_grant;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_fanout_switch #(.NCH(NCH), .DW(DW)) u0 (
        .clk (clk), .rst (rst), .mode_arb (mode_arb), .direct_sel (direct_sel),
        .chan_enable (chan_enable), .s_tdata (s_tdata), .s_tvalid (s_tvalid),
        .s_tlast (s_tlast), .s_tready (s_tready), .m_tdata (m_tdata),
        .m_tvalid (m_tvalid), .m_tlast (m_tlast), .m_tready (m_tready)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return NCH'(1) << i;
        return '0;
    endfunction

    function automatic logic [NCH-1:0] next_rr(input logic [NCH-1:0] g, input logic [NCH-1:0] en);
        int c = 0;
        for (int i = 0; i < NCH; i++) if (g[i]) c = i;
        for (int k = 1; k <= NCH; k++) if (en[(c + k) % NCH]) return NCH'(1) << ((c + k) % NCH);
        return '0;
    endfunction

    task automatic model_reset();
        r_inpkt = 1'b0; r_mode = 1'b0; r_grant = '0;
    endtask

    // Inputs already set at a negedge; check, advance the model, move to next negedge
    task automatic step(input logic v, input logic l, input string tag);
        logic [NCH-1:0] esel, fdv;
        logic ery, acc, np;
        s_tvalid = v; s_tlast = l;
        s_tdata  = {8{$urandom}};
        #1;
        esel = r_mode ? r_grant : direct_sel;
        ery  = |(lowest(esel) & m_tready);
        fdv  = v ? esel : '0;
        chk(m_tvalid == fdv, {tag, " R2 valid gating"}, 64'(m_tvalid), 64'(fdv));
        chk(s_tready == ery, "R3 ready pick", 64'(s_tready), 64'(ery));
        for (int i = 0; i < NCH; i++) begin
            chk(m_tdata[i*DW +: DW] == s_tdata && m_tlast[i] == l,
                "R1 broadcast", 64'(m_tdata[i*DW +: 64]), 64'(s_tdata[63:0]));
        end
        acc = v & ery;
        np  = acc ? ~l : r_inpkt;
        if (acc && l && r_mode)                         r_grant = next_rr(r_grant, chan_enable);
        else if (!np && ((r_grant & chan_enable) == '0)) r_grant = lowest(chan_enable);
        if (!np) r_mode = mode_arb;
        r_inpkt = np;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; s_tvalid = 1'b0; s_tlast = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state, direct mode, nothing granted
        mode_arb = 1'b1; chan_enable = '1; direct_sel = '0; m_tready = '1;
        s_tvalid = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        chk(m_tvalid == '0, "R6 reset valid", 64'(m_tvalid), 64'h0);
        chk(s_tready == 1'b0, "R6 reset ready", 64'(s_tready), 64'h0);
        do_reset();

        // R4 / R3: every direct select pattern with a random ready vector
        mode_arb = 1'b0;
        step(1'b0, 1'b0, "R4");
        for (int d = 0; d < (1 << NCH); d++) begin
            direct_sel = NCH'(d);
            m_tready   = NCH'($urandom);
            step(1'b1, 1'b1, "R4");
            step(1'b0, 1'b0, "R4");
        end

        // R5 / R6 / R7 / R8: every enable pattern, packets of 1..3 beats
        for (int e = 0; e < (1 << NCH); e++) begin
            do_reset();
            mode_arb = 1'b1; chan_enable = NCH'(e); m_tready = '1; direct_sel = '0;
            step(1'b0, 1'b0, "R6");
            for (int p = 0; p < 5; p++) begin
                for (int b = 0; b < (p % 3) + 1; b++) begin
                    string tg;
                    tg = (e == 0) ? "R5" : (p == 0 && b == 0) ? "R6" : (b > 0) ? "R8" : "R7";
                    step(1'b1, (b == (p % 3)), tg);
                end
            end
        end

        // R9: mode and enable changes inside a packet are held back
        do_reset();
        mode_arb = 1'b1; chan_enable = 8'h06; m_tready = '1;
        step(1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, "R9");
        chan_enable = 8'h08; mode_arb = 1'b0; direct_sel = 8'h80;
        step(1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, "R9");
        step(1'b1, 1'b1, "R9");

        // R10: grant dropped from the enable set while idle
        do_reset();
        mode_arb = 1'b1; chan_enable = 8'h0C;
        step(1'b0, 1'b0, "R10");
        step(1'b1, 1'b1, "R10");
        chan_enable = 8'h30;
        step(1'b0, 1'b0, "R10");
        step(1'b1, 1'b0, "R10");
        chan_enable = 8'h00;
        step(1'b1, 1'b1, "R10");
        step(1'b1, 1'b0, "R10");

        // R8 / R9: random stalls, unaccepted ends, changes at random points
        do_reset();
        for (int n = 0; n < 600; n++) begin
            m_tready = NCH'($urandom);
            if (($urandom % 8) == 0) begin
                chan_enable = NCH'($urandom);
                mode_arb    = ($urandom % 4) != 0;
                direct_sel  = NCH'($urandom);
            end
            step(($urandom % 4) != 0, ($urandom % 3) == 0, "R8");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule